// File: doc/BRIEF.md
# Dual-Issue Multiply-Subtract Execute Unit

This block is one execute stage that carries out an integer multiply and an integer subtract side by side, both taken from a single instruction. The operand fetch logic hands it four 32-bit source values in encoded field order. A 2-bit routing code states which fields feed the multiplier and which feed the subtractor. Both operations use values captured at issue. One clock later, each result leaves on its own write port with its own destination index, so a later register write cannot change what either unit already consumed.

The multiplier takes the low 24 bits of each of its operands as signed numbers and forms a 48-bit product. The subtractor works on full 32-bit two's-complement values. Each side detects its own overflow. When the saturation control is set, an overflowing result is clamped to the most positive or most negative 32-bit value, chosen by the sign of the true result. The unit holds an overflow flag and a sticky overflow flag. These change only when the instruction targets one of the low general registers.

Top module: `mulsub_exec`

## Requirements
- R1: Routing code 2'b00 gives product = field3 × field4 and difference = field1 − field2.
- R2: Routing code 2'b01 gives product = field3 × field1 and difference = field4 − field2.
- R3: Routing code 2'b10 gives product = field1 × field2 and difference = field3 − field4.
- R4: Routing code 2'b11 gives product = field3 × field1 and difference = field2 − field4.
- R5: The multiplier reads bits 23:0 of each operand as signed values and ignores bits 31:24. With no saturation, the low 32 bits of the 48-bit product are written.
- R6: A multiply overflows when any of product bits 47:32 differs from bit 31. With saturation set, an overflowing product is written as 32'h7FFFFFFF if it is positive and 32'h80000000 if it is negative.
- R7: A subtract overflows when the operand signs differ and the result sign differs from the minuend sign. With saturation set, it is written as 32'h7FFFFFFF for a non-negative minuend and 32'h80000000 otherwise. With saturation clear, the wrapped 32-bit difference is written.
- R8: One cycle after an issued instruction, both write enables are high, carrying the two results and their destination indices. A cycle with no issue produces no write on either port.
- R9: Flags update on an issue only if at least one destination index is below 8. V then equals the OR of the two overflows, and sticky LV is set by an overflow and otherwise keeps its value. If neither destination is below 8, V and LV are unchanged.
- R10: Operands are captured at issue. An instruction whose subtract destination is also a multiply source register gets a product computed from the value that register held before the write.
- R11: A synchronous reset clears both write enables, V and LV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction valid this cycle |
| fld1 | input | 32 | Source operand, field 1 |
| fld2 | input | 32 | Source operand, field 2 |
| fld3 | input | 32 | Source operand, field 3 |
| fld4 | input | 32 | Source operand, field 4 |
| route | input | 2 | Operand routing code |
| sat_en | input | 1 | Saturate overflowing results |
| mul_dst | input | 5 | Multiply destination index |
| sub_dst | input | 5 | Subtract destination index |
| mul_we | output | 1 | Multiply write enable |
| mul_waddr | output | 5 | Multiply write index |
| mul_wdata | output | 32 | Multiply result |
| sub_we | output | 1 | Subtract write enable |
| sub_waddr | output | 5 | Subtract write index |
| sub_wdata | output | 32 | Subtract result |
| flag_v | output | 1 | Overflow flag |
| flag_lv | output | 1 | Sticky overflow flag |

## Verification
In a single cycle the block can commit a multiply and a subtract whose destination is a register the multiply just read. It can also raise overflow from both units at once. The bench's register model sets up the hazard and then changes the operand buses during the commit cycle. The product must match the register's earlier contents, and the subtract result must land in that register. Separate vectors make one unit overflow while the other does not. Together with runs that target destinations at or above 8, these show that V merges both overflows and updates only for the low registers.

// File: rtl/mulsub_pkg.sv
package mulsub_pkg;
  typedef enum logic [1:0] {
    RT_MA_SA = 2'b00,
    RT_MB_SB = 2'b01,
    RT_MC_SC = 2'b10,
    RT_MD_SD = 2'b11
  } route_e;

  function automatic logic [31:0] clamp32(input logic neg);
    return neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
  endfunction
endpackage

// File: rtl/mulsub_route.sv
module mulsub_route #(
  parameter int W = 32
) (
  input  logic [W-1:0] f1,
  input  logic [W-1:0] f2,
  input  logic [W-1:0] f3,
  input  logic [W-1:0] f4,
  input  logic [1:0]   route,
  output logic [W-1:0] mul_a,
  output logic [W-1:0] mul_b,
  output logic [W-1:0] sub_a,
  output logic [W-1:0] sub_b
);
  import mulsub_pkg::*;

  always_comb begin
    unique case (route_e'(route))
      RT_MA_SA: begin mul_a = f3; mul_b = f4; sub_a = f1; sub_b = f2; end
      RT_MB_SB: begin mul_a = f3; mul_b = f1; sub_a = f4; sub_b = f2; end
      RT_MC_SC: begin mul_a = f1; mul_b = f2; sub_a = f3; sub_b = f4; end
      default:  begin mul_a = f3; mul_b = f1; sub_a = f2; sub_b = f4; end
    endcase
  end
endmodule

// File: rtl/mulsub_mul.sv
module mulsub_mul #(
  parameter int W  = 32,
  parameter int MW = 24
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int PW = 2 * MW;

  logic signed [MW-1:0] sa, sb;
  logic signed [PW-1:0] prod;
  logic [PW-W:0]        top_bits;

  assign sa       = a[MW-1:0];
  assign sb       = b[MW-1:0];
  assign prod     = sa * sb;
  assign top_bits = prod[PW-1:W-1];
  assign ovf      = !((&top_bits) || !(|top_bits));

  always_comb begin
    if (sat_en && ovf)
      res = prod[PW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      res = prod[W-1:0];
  end

  always_comb begin
    if (sat_en && ovf)
      AST_MUL_CLAMP: assert (res == {1'b1, {(W-1){1'b0}}} || res == {1'b0, {(W-1){1'b1}}}); // R6
  end
endmodule

// File: rtl/mulsub_sub.sv
module mulsub_sub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output logic         ovf
);
  logic [W-1:0] diff;

  assign diff = a - b;
  assign ovf  = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);

  always_comb begin
    if (sat_en && ovf)
      res = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      res = diff;
  end

  always_comb begin
    if (!ovf)
      AST_SUB_EXACT: assert (res + b == a); // R7
  end
endmodule

// File: rtl/mulsub_exec.sv
module mulsub_exec #(
  parameter int W        = 32,
  parameter int MW       = 24,
  parameter int AW       = 5,
  parameter int NUM_GPR  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [W-1:0]  fld1,
  input  logic [W-1:0]  fld2,
  input  logic [W-1:0]  fld3,
  input  logic [W-1:0]  fld4,
  input  logic [1:0]    route,
  input  logic          sat_en,
  input  logic [AW-1:0] mul_dst,
  input  logic [AW-1:0] sub_dst,
  output logic          mul_we,
  output logic [AW-1:0] mul_waddr,
  output logic [W-1:0]  mul_wdata,
  output logic          sub_we,
  output logic [AW-1:0] sub_waddr,
  output logic [W-1:0]  sub_wdata,
  output logic          flag_v,
  output logic          flag_lv
);
  localparam logic [AW-1:0] GPR_LIM = AW'(NUM_GPR);

  logic [W-1:0] mul_a, mul_b, sub_a, sub_b;
  logic [W-1:0] mul_res, sub_res;
  logic         mul_ovf, sub_ovf, ovf_any, flag_upd;

  mulsub_route #(.W(W)) route_i (
    .f1(fld1), .f2(fld2), .f3(fld3), .f4(fld4), .route(route),
    .mul_a(mul_a), .mul_b(mul_b), .sub_a(sub_a), .sub_b(sub_b)
  );

  mulsub_mul #(.W(W), .MW(MW)) mul_i (
    .a(mul_a), .b(mul_b), .sat_en(sat_en), .res(mul_res), .ovf(mul_ovf)
  );

  mulsub_sub #(.W(W)) sub_i (
    .a(sub_a), .b(sub_b), .sat_en(sat_en), .res(sub_res), .ovf(sub_ovf)
  );

  assign ovf_any  = mul_ovf || sub_ovf;
  assign flag_upd = issue && ((mul_dst < GPR_LIM) || (sub_dst < GPR_LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_we    <= 1'b0;
      sub_we    <= 1'b0;
      mul_waddr <= '0;
      sub_waddr <= '0;
      mul_wdata <= '0;
      sub_wdata <= '0;
    end else begin
      mul_we <= issue;
      sub_we <= issue;
      if (issue) begin
        mul_waddr <= mul_dst;
        sub_waddr <= sub_dst;
        mul_wdata <= mul_res;
        sub_wdata <= sub_res;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_v  <= 1'b0;
      flag_lv <= 1'b0;
    end else if (flag_upd) begin
      flag_v  <= ovf_any;
      flag_lv <= flag_lv || ovf_any;
    end
  end

  AST_WRITE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue |=> (mul_we && sub_we)); // R8
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !issue |=> (!mul_we && !sub_we)); // R8
  AST_DISTINCT_DST: assert property (@(posedge clk) disable iff (rst)
    issue |-> (mul_dst != sub_dst)); // R8
  AST_LV_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag_lv |=> flag_lv); // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_upd |=> ($stable(flag_v) && $stable(flag_lv))); // R9
  AST_V_SETS_LV: assert property (@(posedge clk) disable iff (rst)
    flag_v |-> flag_lv); // R9
endmodule

// File: tb/mulsub_exec_tb_top.sv
module mulsub_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [31:0] fld1, fld2, fld3, fld4;
  logic [1:0]  route;
  logic        sat_en;
  logic [4:0]  mul_dst, sub_dst;
  logic        mul_we, sub_we, flag_v, flag_lv;
  logic [4:0]  mul_waddr, sub_waddr;
  logic [31:0] mul_wdata, sub_wdata;

  int checks = 0;
  int fails  = 0;
  logic [31:0] regs [32];

  always #2 clk = ~clk;

  mulsub_exec dut_i (
    .clk(clk), .rst(rst), .issue(issue),
    .fld1(fld1), .fld2(fld2), .fld3(fld3), .fld4(fld4),
    .route(route), .sat_en(sat_en), .mul_dst(mul_dst), .sub_dst(sub_dst),
    .mul_we(mul_we), .mul_waddr(mul_waddr), .mul_wdata(mul_wdata),
    .sub_we(sub_we), .sub_waddr(sub_waddr), .sub_wdata(sub_wdata),
    .flag_v(flag_v), .flag_lv(flag_lv)
  );

  typedef struct packed {
    logic [31:0] f1, f2, f3, f4;
    logic [1:0]  rt;
    logic        sat;
    logic [31:0] em, es;
    logic        ev;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'd100, 32'd30, 32'd7, 32'd6, 2'b00, 1'b0, 32'd42, 32'd70, 1'b0},                    // R1
    '{32'd5, 32'd10, 32'hFFFF_FFFD, 32'd1000, 2'b01, 1'b0, 32'hFFFF_FFF1, 32'd990, 1'b0},   // R2
    '{32'h1000, 32'h100, 32'd50, 32'd80, 2'b10, 1'b0, 32'h0010_0000, 32'hFFFF_FFE2, 1'b0},  // R3
    '{32'd9, 32'h10, 32'h1200_0004, 32'h20, 2'b11, 1'b0, 32'h24, 32'hFFFF_FFF0, 1'b0},      // R4 R5
    '{32'h40_0000, 32'h40_0000, 32'd1, 32'd1, 2'b10, 1'b0, 32'h0, 32'h0, 1'b1},             // R6 wrap
    '{32'h40_0000, 32'h40_0000, 32'd1, 32'd1, 2'b10, 1'b1, 32'h7FFF_FFFF, 32'h0, 1'b1},     // R6 sat
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd2, 32'd3, 2'b00, 1'b1, 32'd6, 32'h7FFF_FFFF, 1'b1}, // R7 sat
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd2, 32'd3, 2'b00, 1'b0, 32'd6, 32'h8000_0000, 1'b1}, // R7 wrap
    '{32'd0, 32'd0, 32'h80_0000, 32'h100, 2'b00, 1'b1, 32'h8000_0000, 32'h0, 1'b0},         // R6 edge
    '{32'd0, 32'd0, 32'h80_0000, 32'h200, 2'b00, 1'b1, 32'h8000_0000, 32'h0, 1'b1}          // R6 neg
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, b, c, d, input logic [1:0] rt,
                        input logic sat, input logic [4:0] md, sd);
    @(negedge clk);
    fld1 = a; fld2 = b; fld3 = c; fld4 = d;
    route = rt; sat_en = sat; mul_dst = md; sub_dst = sd; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] old3;
    rst = 1'b1; issue = 1'b0; fld1 = '0; fld2 = '0; fld3 = '0; fld4 = '0;
    route = '0; sat_en = 1'b0; mul_dst = 5'd0; sub_dst = 5'd1;
    repeat (3) @(negedge clk);
    chk("R11 mul_we", {31'b0, mul_we}, 32'd0);
    chk("R11 sub_we", {31'b0, sub_we}, 32'd0);
    chk("R11 flags", {30'b0, flag_v, flag_lv}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].f1, VECS[i].f2, VECS[i].f3, VECS[i].f4, VECS[i].rt,
             VECS[i].sat, 5'd1, 5'd2);
      chk($sformatf("R1-4 vec%0d mul", i), mul_wdata, VECS[i].em);
      chk($sformatf("R1-4 vec%0d sub", i), sub_wdata, VECS[i].es);
      chk($sformatf("R9 vec%0d V", i), {31'b0, flag_v}, {31'b0, VECS[i].ev});
      chk($sformatf("R8 vec%0d we", i), {30'b0, mul_we, sub_we}, 32'd3);
      chk($sformatf("R8 vec%0d addr", i), {22'b0, mul_waddr, sub_waddr}, {22'b0, 5'd1, 5'd2});
    end

    // R8: idle cycle writes nothing
    @(negedge clk);
    chk("R8 idle we", {30'b0, mul_we, sub_we}, 32'd0);

    // R9: LV sticky after overflow, V cleared by clean op
    run_op(32'd4, 32'd1, 32'd2, 32'd2, 2'b00, 1'b0, 5'd3, 5'd4);
    chk("R9 V clean", {31'b0, flag_v}, 32'd0);
    chk("R9 LV sticky", {31'b0, flag_lv}, 32'd1);

    // R9: high destinations leave flags alone
    run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'd1, 2'b00, 1'b0, 5'd10, 5'd11);
    chk("R9 gated V", {31'b0, flag_v}, 32'd0);
    chk("R9 gated data", sub_wdata, 32'h8000_0000);
    run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'd1, 2'b00, 1'b0, 5'd12, 5'd5);
    chk("R9 mixed dst V", {31'b0, flag_v}, 32'd1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R11 reset clears LV", {31'b0, flag_lv}, 32'd0);
    run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'd1, 2'b00, 1'b0, 5'd20, 5'd21);
    chk("R9 gated LV", {31'b0, flag_lv}, 32'd0);

    // R10: subtract writes a register the multiply reads
    for (int r = 0; r < 32; r++) regs[r] = 32'(r * 3 + 1);
    old3 = regs[3];
    @(negedge clk);
    fld1 = regs[6]; fld2 = regs[1]; fld3 = regs[2]; fld4 = regs[3];
    route = 2'b00; sat_en = 1'b0; mul_dst = 5'd7; sub_dst = 5'd3; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    if (sub_we) regs[sub_waddr] = sub_wdata;
    if (mul_we) regs[mul_waddr] = mul_wdata;
    fld4 = regs[3];
    @(posedge clk); #1;
    chk("R10 old operand", regs[7], regs[2] * old3);
    chk("R10 sub landed", regs[3], 32'd19 - 32'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule